// File: doc/BRIEF.md
# Register Read-Port Request Generator

This block sits between the instruction decoder and an ALU-class function unit. It takes one decoded instruction record and produces read requests for each operand port the unit owns. There are two integer source ports, called A and B. There are also two flag ports on the fixed-point exception register: one for the summary-overflow bit, and one for the carry pair (carry and its 32-bit twin). The block also produces the matching write-side enables for the result register and for those same two flag fields.

Every port gets a pair of signals. The first is a request bit, which says whether the current instruction actually uses that operand. The second is a select vector. For integer ports the select vector is one-hot across the register file, with bit n set for register n. For flag ports it is a bit mask over the 64-bit exception register. A port whose operand is not needed drives an all-zero select, so it never issues a register-file access.

All outputs are combinational from the record. A consumer samples them in the cycle the record's valid strobe is high.

Top module: `rp_req_gen`

## Requirements
- R1: While `dec_valid` is 0, every request output is 0 and every select vector and mask is all-zero, whatever the other inputs are.
- R2: `ra_rd_req` equals `ra_use` when valid. `ra_rd_sel` has only bit `ra_num` set when the request is raised (bit 0 is register 0, bit 31 is register 31).
- R3: A B-port read is raised only when `rb_use` is 1 and `rb_imm` is 0. When the B operand is an immediate, `rb_rd_req` is 0 and `rb_rd_sel` is all-zero. Otherwise `rb_rd_sel` has only bit `rb_num` set.
- R4: Each integer select vector has exactly one bit set when its request is raised, and no bit set when it is not.
- R5: The summary-overflow read (`so_rd_req`) is raised exactly when `oe` is 1. Its mask `so_rd_mask` is then 64'h0000_0001_0000_0000, which is bit 32 only.
- R6: The carry read (`ca_rd_req`) is raised only when `cin_sel` is 2 ("take carry flag"). Codes 0 (zero), 1 (one) and 3 (reserved) raise no carry read. The mask `ca_rd_mask` is then bits 34 and 45, which is 64'h0000_2004_0000_0000.
- R7: `rt_wr_req` equals `rt_use` when valid. `rt_wr_sel` is one-hot with bit `rt_num` set, and is all-zero when the request is not raised.
- R8: `so_wr_req` follows `oe` and `ca_wr_req` follows `cout`. Their masks are the same bit patterns as in R5 and R6 when raised, and zero otherwise.
- R9: Every output reflects the present inputs in the same cycle, with no register stage in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dec_valid | input | 1 | Decoded record is valid this cycle |
| ra_use | input | 1 | Instruction reads operand A |
| ra_num | input | 5 | Register number of operand A |
| rb_use | input | 1 | Instruction has a B operand |
| rb_imm | input | 1 | B operand is an immediate, not a register |
| rb_num | input | 5 | Register number of operand B |
| oe | input | 1 | Overflow-enable bit of the instruction |
| cin_sel | input | 2 | Carry-in source: 0 zero, 1 one, 2 carry flag, 3 reserved |
| rt_use | input | 1 | Instruction writes a result register |
| rt_num | input | 5 | Destination register number |
| cout | input | 1 | Instruction updates the carry pair |
| ra_rd_req | output | 1 | Read request, port A |
| ra_rd_sel | output | 32 | One-hot register select, port A |
| rb_rd_req | output | 1 | Read request, port B |
| rb_rd_sel | output | 32 | One-hot register select, port B |
| so_rd_req | output | 1 | Read request, summary-overflow flag |
| so_rd_mask | output | 64 | Exception-register bit mask for that read |
| ca_rd_req | output | 1 | Read request, carry pair |
| ca_rd_mask | output | 64 | Exception-register bit mask for that read |
| rt_wr_req | output | 1 | Write enable, result register |
| rt_wr_sel | output | 32 | One-hot register select for the write |
| so_wr_req | output | 1 | Write enable, summary-overflow flag |
| so_wr_mask | output | 64 | Mask for the summary-overflow write |
| ca_wr_req | output | 1 | Write enable, carry pair |
| ca_wr_mask | output | 64 | Mask for the carry-pair write |

## Verification
Every result is due in the same cycle as the record that causes it, because the path from inputs to outputs has no register. The bench applies each record a few nanoseconds after a rising edge. It then samples all outputs a few nanoseconds later, still well before the next edge, so every check reads a fully settled combinational value and never a value from a neighbouring record. Random records cover the general function. Directed records cover valid low, an immediate B operand, each carry-in code, and registers 0 and 31.

// File: rtl/rp_pkg.sv
package rp_pkg;

  // Carry-in source as decoded from the instruction record
  typedef enum logic [1:0] {
    CIN_ZERO = 2'd0,
    CIN_ONE  = 2'd1,
    CIN_FLAG = 2'd2,
    CIN_RSVD = 2'd3
  } cin_sel_e;

  // Index of each flag port in the flag-port array of the top
  localparam int FP_SO_RD = 0;
  localparam int FP_CA_RD = 1;
  localparam int FP_SO_WR = 2;
  localparam int FP_CA_WR = 3;
  localparam int NUM_FLAG_PORTS = 4;

endpackage

// File: rtl/rp_need_decode.sv
module rp_need_decode
  import rp_pkg::*;
(
  input  logic       dec_valid,
  input  logic       ra_use,
  input  logic       rb_use,
  input  logic       rb_imm,
  input  logic       oe,
  input  logic [1:0] cin_sel,
  input  logic       rt_use,
  input  logic       cout,
  output logic       ra_need,
  output logic       rb_need,
  output logic       so_rd_need,
  output logic       ca_rd_need,
  output logic       rt_need,
  output logic       so_wr_need,
  output logic       ca_wr_need
);

  cin_sel_e cin;
  logic     carry_from_flag;

  assign cin             = cin_sel_e'(cin_sel);
  assign carry_from_flag = (cin == CIN_FLAG);

  always_comb begin
    ra_need    = dec_valid & ra_use;
    rb_need    = dec_valid & rb_use & ~rb_imm;
    so_rd_need = dec_valid & oe;
    ca_rd_need = dec_valid & carry_from_flag;
    rt_need    = dec_valid & rt_use;
    so_wr_need = dec_valid & oe;
    ca_wr_need = dec_valid & cout;
  end

  // R3: an immediate B operand never produces a B read
  always_comb begin
    p_imm_no_read_r3: assert (!(rb_imm && rb_need))
      else $error("B read raised for immediate operand");
  end

  // R6: carry read only for the flag source
  always_comb begin
    p_carry_source_r6: assert (!ca_rd_need || cin_sel == 2'd2)
      else $error("carry read raised for non-flag source");
  end

endmodule

// File: rtl/rp_int_port.sv
module rp_int_port #(
  parameter int NREG  = 32,
  localparam int NUMW = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic            need_i,
  input  logic [NUMW-1:0] num_i,
  output logic            req_o,
  output logic [NREG-1:0] sel_o
);

  // Unary encoding of a register number
  function automatic logic [NREG-1:0] unary(input logic [NUMW-1:0] n);
    logic [NREG-1:0] v;
    v = '0;
    for (int i = 0; i < NREG; i++) begin
      if (NUMW'(i) == n) v[i] = 1'b1;
    end
    return v;
  endfunction

  logic [NREG-1:0] raw_sel;

  assign raw_sel = unary(num_i);
  assign req_o   = need_i;
  assign sel_o   = need_i ? raw_sel : '0;

  // R4: the select vector carries exactly one bit while requested, none otherwise
  always_comb begin
    p_sel_onehot_r4: assert ($countones(sel_o) == (req_o ? 1 : 0))
      else $error("select vector not consistent with request");
  end

endmodule

// File: rtl/rp_flag_port.sv
module rp_flag_port #(
  parameter int            XW   = 64,
  parameter logic [XW-1:0] MASK = '0
) (
  input  logic          need_i,
  output logic          req_o,
  output logic [XW-1:0] mask_o
);

  assign req_o  = need_i;
  assign mask_o = need_i ? MASK : '0;

  // A raised mask never touches bits outside the port's field
  always_comb begin
    p_mask_in_field: assert ((mask_o & ~MASK) == '0)
      else $error("flag mask outside field");
  end

endmodule

// File: rtl/rp_req_gen.sv
module rp_req_gen
  import rp_pkg::*;
#(
  parameter int NREG     = 32,
  parameter int XW       = 64,
  parameter int SO_BIT   = 32,
  parameter int CA_BIT   = 34,
  parameter int CA32_BIT = 45,
  localparam int NUMW    = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic            dec_valid,
  input  logic            ra_use,
  input  logic [NUMW-1:0] ra_num,
  input  logic            rb_use,
  input  logic            rb_imm,
  input  logic [NUMW-1:0] rb_num,
  input  logic            oe,
  input  logic [1:0]      cin_sel,
  input  logic            rt_use,
  input  logic [NUMW-1:0] rt_num,
  input  logic            cout,
  output logic            ra_rd_req,
  output logic [NREG-1:0] ra_rd_sel,
  output logic            rb_rd_req,
  output logic [NREG-1:0] rb_rd_sel,
  output logic            so_rd_req,
  output logic [XW-1:0]   so_rd_mask,
  output logic            ca_rd_req,
  output logic [XW-1:0]   ca_rd_mask,
  output logic            rt_wr_req,
  output logic [NREG-1:0] rt_wr_sel,
  output logic            so_wr_req,
  output logic [XW-1:0]   so_wr_mask,
  output logic            ca_wr_req,
  output logic [XW-1:0]   ca_wr_mask
);

  localparam logic [XW-1:0] SO_MASK = XW'(1) << SO_BIT;
  localparam logic [XW-1:0] CA_MASK = (XW'(1) << CA_BIT) | (XW'(1) << CA32_BIT);
  localparam int NUM_INT = 3;  // A read, B read, result write

  // Need flags, brought out by name
  logic ra_need, rb_need, so_rd_need, ca_rd_need;
  logic rt_need, so_wr_need, ca_wr_need;

  rp_need_decode u_need (
    .dec_valid  (dec_valid),
    .ra_use     (ra_use),
    .rb_use     (rb_use),
    .rb_imm     (rb_imm),
    .oe         (oe),
    .cin_sel    (cin_sel),
    .rt_use     (rt_use),
    .cout       (cout),
    .ra_need    (ra_need),
    .rb_need    (rb_need),
    .so_rd_need (so_rd_need),
    .ca_rd_need (ca_rd_need),
    .rt_need    (rt_need),
    .so_wr_need (so_wr_need),
    .ca_wr_need (ca_wr_need)
  );

  // Integer ports
  logic [NUM_INT-1:0]           int_need;
  logic [NUM_INT-1:0][NUMW-1:0] int_num;
  logic [NUM_INT-1:0]           int_req;
  logic [NUM_INT-1:0][NREG-1:0] int_sel;

  assign int_need = {rt_need, rb_need, ra_need};
  assign int_num  = {rt_num, rb_num, ra_num};

  for (genvar g = 0; g < NUM_INT; g++) begin : g_int
    rp_int_port #(.NREG(NREG)) u_port (
      .need_i (int_need[g]),
      .num_i  (int_num[g]),
      .req_o  (int_req[g]),
      .sel_o  (int_sel[g])
    );
  end

  assign ra_rd_req = int_req[0];
  assign ra_rd_sel = int_sel[0];
  assign rb_rd_req = int_req[1];
  assign rb_rd_sel = int_sel[1];
  assign rt_wr_req = int_req[2];
  assign rt_wr_sel = int_sel[2];

  // Flag ports on the exception register
  logic [NUM_FLAG_PORTS-1:0]         fl_need;
  logic [NUM_FLAG_PORTS-1:0]         fl_req;
  logic [NUM_FLAG_PORTS-1:0][XW-1:0] fl_mask;

  always_comb begin
    fl_need           = '0;
    fl_need[FP_SO_RD] = so_rd_need;
    fl_need[FP_CA_RD] = ca_rd_need;
    fl_need[FP_SO_WR] = so_wr_need;
    fl_need[FP_CA_WR] = ca_wr_need;
  end

  for (genvar f = 0; f < NUM_FLAG_PORTS; f++) begin : g_flag
    localparam logic [XW-1:0] FMASK =
      (f == FP_SO_RD || f == FP_SO_WR) ? SO_MASK : CA_MASK;
    rp_flag_port #(.XW(XW), .MASK(FMASK)) u_port (
      .need_i (fl_need[f]),
      .req_o  (fl_req[f]),
      .mask_o (fl_mask[f])
    );
  end

  assign so_rd_req  = fl_req[FP_SO_RD];
  assign so_rd_mask = fl_mask[FP_SO_RD];
  assign ca_rd_req  = fl_req[FP_CA_RD];
  assign ca_rd_mask = fl_mask[FP_CA_RD];
  assign so_wr_req  = fl_req[FP_SO_WR];
  assign so_wr_mask = fl_mask[FP_SO_WR];
  assign ca_wr_req  = fl_req[FP_CA_WR];
  assign ca_wr_mask = fl_mask[FP_CA_WR];

  // R1: an invalid record raises nothing on any port
  always_comb begin
    p_idle_quiet_r1: assert (dec_valid ||
      (int_req == '0 && fl_req == '0 && int_sel == '0 && fl_mask == '0))
      else $error("request raised without valid record");
  end

  // R5: summary-overflow read only with overflow enable
  always_comb begin
    p_so_read_oe_r5: assert (!so_rd_req || oe)
      else $error("SO read without OE");
  end

  // R8: flag write enables only follow their instruction bits
  always_comb begin
    p_flag_write_r8: assert ((!so_wr_req || oe) && (!ca_wr_req || cout))
      else $error("flag write without its source bit");
  end

endmodule

// File: tb/rp_req_gen_bench.sv
module rp_req_gen_bench;

  logic clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic        dec_valid, ra_use, rb_use, rb_imm, oe, rt_use, cout;
  logic [4:0]  ra_num, rb_num, rt_num;
  logic [1:0]  cin_sel;
  logic        ra_rd_req, rb_rd_req, so_rd_req, ca_rd_req;
  logic        rt_wr_req, so_wr_req, ca_wr_req;
  logic [31:0] ra_rd_sel, rb_rd_sel, rt_wr_sel;
  logic [63:0] so_rd_mask, ca_rd_mask, so_wr_mask, ca_wr_mask;

  rp_req_gen u_rp_req_gen (.*);

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  localparam logic [63:0] SO_FIELD = 64'h0000_0001_0000_0000;
  localparam logic [63:0] CA_FIELD = 64'h0000_2004_0000_0000;

  function automatic logic [31:0] exp_onehot(input bit en, input int n);
    logic [31:0] v = '0;
    if (en) v[n] = 1'b1;
    return v;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply_and_check(
    input bit v, input bit au, input int an, input bit bu, input bit bi,
    input int bn, input bit o, input int cs, input bit tu, input int tn,
    input bit co);
    bit ea, eb, eso, eca, et, eco;
    @(posedge clk);
    #2;
    dec_valid = v; ra_use = au; ra_num = 5'(an); rb_use = bu; rb_imm = bi;
    rb_num = 5'(bn); oe = o; cin_sel = 2'(cs); rt_use = tu; rt_num = 5'(tn);
    cout = co;
    #2;  // R9: same-cycle result, sampled before the next edge
    ea  = v && au;
    eb  = v && bu && !bi;
    eso = v && o;
    eca = v && (cs == 2);
    et  = v && tu;
    eco = v && co;
    chk("R2 ra_rd_req", 64'(ra_rd_req), 64'(ea));
    chk("R2 R4 ra_rd_sel", 64'(ra_rd_sel), 64'(exp_onehot(ea, an)));
    chk("R3 rb_rd_req", 64'(rb_rd_req), 64'(eb));
    chk("R3 R4 rb_rd_sel", 64'(rb_rd_sel), 64'(exp_onehot(eb, bn)));
    chk("R5 so_rd_req", 64'(so_rd_req), 64'(eso));
    chk("R5 so_rd_mask", so_rd_mask, eso ? SO_FIELD : 64'd0);
    chk("R6 ca_rd_req", 64'(ca_rd_req), 64'(eca));
    chk("R6 ca_rd_mask", ca_rd_mask, eca ? CA_FIELD : 64'd0);
    chk("R7 rt_wr_req", 64'(rt_wr_req), 64'(et));
    chk("R7 rt_wr_sel", 64'(rt_wr_sel), 64'(exp_onehot(et, tn)));
    chk("R8 so_wr", {so_wr_mask[62:0], so_wr_req}, {(eso ? SO_FIELD[62:0] : 63'd0), eso});
    chk("R8 ca_wr", {ca_wr_mask[62:0], ca_wr_req}, {(eca ? 1'b0 : 1'b0) | (eco ? CA_FIELD[62:0] : 63'd0), eco});
  endtask

  initial begin
    int seed;
    seed = 32'h5eed_1234;
    void'($urandom(seed));
    // R1: reset-like idle record with every use bit high but valid low
    apply_and_check(0, 1, 7, 1, 0, 9, 1, 2, 1, 3, 1);
    // R3: immediate B operand
    apply_and_check(1, 1, 4, 1, 1, 12, 0, 0, 1, 4, 0);
    // single-operand negate-like record: only A
    apply_and_check(1, 1, 31, 0, 0, 5, 0, 1, 1, 0, 0);
    // two-operand add with overflow enable, registers 0 and 31
    apply_and_check(1, 1, 0, 1, 0, 31, 1, 0, 1, 31, 0);
    // R6: each carry-in code
    for (int c = 0; c < 4; c++) apply_and_check(1, 1, c, 1, 0, c + 8, 0, c, 0, 0, 1);
    // R1 again after activity
    apply_and_check(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    // random records
    for (int i = 0; i < 400; i++) begin
      apply_and_check(($urandom % 8) != 0, 1'($urandom), int'($urandom % 32),
                      1'($urandom), 1'($urandom), int'($urandom % 32),
                      1'($urandom), int'($urandom % 4), 1'($urandom),
                      int'($urandom % 32), 1'($urandom));
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
      end
    join_any
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule